// File: doc/BRIEF.md
# Serial/Parallel Divider Configuration Loader

This block is the programming front end of a clock synthesizer. It keeps three values: a 9-bit feedback divide ratio, a 2-bit output divide code and a 3-bit test-select code. These values can be written in two ways. The first is a parallel bus that follows its inputs while an active-low load pin is low. The second is a 14-bit serial shift register, fed by a serial clock and data line and committed by a serial strobe.

Every external control line is brought into the system clock domain through a synchronizer whose depth is a parameter. All edges are then found by comparing registered samples. Each update of the active values therefore appears `SYNC_STAGES + 1` system clocks after the input change that caused it. Whichever path acts last sets the active values. The parallel path overrides everything while its load pin is low.

Top module: `cfg_loader`

## Requirements
- R1: After reset, `m_val`, `n_val`, `t_val` and `ser_out` are all zero, and the parallel path is treated as latched (load pin high).
- R2: While `par_load_n` is low, `m_val` and `n_val` follow `par_m` and `par_n`, and `t_val` is forced to 3'b000.
- R3: After `par_load_n` rises, the active values hold even when `par_m` and `par_n` change afterwards.
- R4: Each rising edge of `ser_clk` with `par_load_n` high shifts `ser_data` into bit 0 of the 14-bit register, toward the MSB. `ser_out` is bit 13. A frame is sent T2 first and M0 last, so after 14 clocks bits [13:11] hold T, [10:9] hold N and [8:0] hold M.
- R5: A rising edge of `ser_strobe` with `par_load_n` high copies the register to the active values: T from bits [13:11], N from [10:9], M from [8:0].
- R6: While `ser_strobe` is held high, every rising edge of `ser_clk` passes the newly shifted register contents straight to the active values.
- R7: After `ser_strobe` falls, the active values hold while further serial bits are shifted in.
- R8: Rising edges of `ser_clk` while `par_load_n` is low leave the shift register (and `ser_out`) unchanged.
- R9: A serial load replaces values latched from the parallel path. A later low on `par_load_n` replaces serially loaded values.
- R10: With an all-ones frame, every active bit reads one (M = 511, N = 3, T = 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n | input | 1 | Parallel load, low = transparent |
| par_m | input | M_W | Parallel feedback divide value |
| par_n | input | N_W | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_data | input | 1 | Serial data bit |
| ser_strobe | input | 1 | Serial commit strobe |
| m_val | output | M_W | Active feedback divide value |
| n_val | output | N_W | Active output divide code |
| t_val | output | T_W | Active test-select code |
| ser_out | output | 1 | Last stage of the shift register |

## Verification
The parallel path is tried with two distinct words while transparent, then with changed inputs after the latch edge. This separates following the inputs from holding them. Serial frames with asymmetric T, N and M contents show bit order and field placement. Shifting with the strobe low, strobing, and shifting again with the strobe held high separate the commit, hold and pass-through behaviours. Serial clocks sent while the parallel pin is low, followed by a strobe, show whether the register was frozen. An all-ones frame covers the field boundaries.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
   localparam int DEF_M_W = 9;
   localparam int DEF_N_W = 2;
   localparam int DEF_T_W = 3;

   typedef enum logic [1:0] {
      SRC_HOLD = 2'd0,
      SRC_PAR  = 2'd1,
      SRC_SER  = 2'd2
   } upd_src_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cfg_edge.sv
module cfg_edge #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] q,
   output logic [W-1:0] nxt
);
   assign nxt = shift_en ? {q[W-2:0], din} : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/cfg_active.sv
module cfg_active
   import cfg_loader_pkg::*;
#(
   parameter int M_W = DEF_M_W,
   parameter int N_W = DEF_N_W,
   parameter int T_W = DEF_T_W,
   localparam int FRAME_W = T_W + N_W + M_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  upd_src_e           src,
   input  logic [M_W-1:0]     par_m,
   input  logic [N_W-1:0]     par_n,
   input  logic [FRAME_W-1:0] ser_word,
   output logic [M_W-1:0]     m_q,
   output logic [N_W-1:0]     n_q,
   output logic [T_W-1:0]     t_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q <= '0;
         n_q <= '0;
         t_q <= '0;
      end else begin
         unique case (src)
            SRC_PAR: begin
               m_q <= par_m;
               n_q <= par_n;
               t_q <= '0;
            end
            SRC_SER: {t_q, n_q, m_q} <= ser_word;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
   import cfg_loader_pkg::*;
#(
   parameter int M_W         = DEF_M_W,
   parameter int N_W         = DEF_N_W,
   parameter int T_W         = DEF_T_W,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           par_load_n,
   input  logic [M_W-1:0] par_m,
   input  logic [N_W-1:0] par_n,
   input  logic           ser_clk,
   input  logic           ser_data,
   input  logic           ser_strobe,
   output logic [M_W-1:0] m_val,
   output logic [N_W-1:0] n_val,
   output logic [T_W-1:0] t_val,
   output logic           ser_out
);
   localparam int FRAME_W = T_W + N_W + M_W;
   localparam int IN_W    = 4 + N_W + M_W;
   localparam logic [IN_W-1:0] IN_RST = {1'b1, {(IN_W-1){1'b0}}};

   generate
      if (M_W < 1 || M_W > 16) begin : g_bad_m
         $error("cfg_loader: M_W out of range");
      end
      if (N_W < 1 || N_W > 8) begin : g_bad_n
         $error("cfg_loader: N_W out of range");
      end
      if (T_W < 1 || T_W > 8) begin : g_bad_t
         $error("cfg_loader: T_W out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("cfg_loader: SYNC_STAGES out of range");
      end
   endgenerate

   // sampled copies of every control input
   logic [IN_W-1:0] raw_bus, syn_bus;
   logic            pl_s, strb_s, sck_s, sd_s;
   logic [N_W-1:0]  par_n_s;
   logic [M_W-1:0]  par_m_s;

   assign raw_bus = {par_load_n, ser_strobe, ser_clk, ser_data, par_n, par_m};

   cfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_bus),
      .q    (syn_bus)
   );

   assign {pl_s, strb_s, sck_s, sd_s, par_n_s, par_m_s} = syn_bus;

   // edge detection on the serial clock and strobe
   logic sck_rise, strb_rise;

   cfg_edge #(.RST_VAL(1'b0)) u_sck_edge (
      .clk(clk), .rst_n(rst_n), .lvl(sck_s), .rise(sck_rise)
   );

   cfg_edge #(.RST_VAL(1'b0)) u_strb_edge (
      .clk(clk), .rst_n(rst_n), .lvl(strb_s), .rise(strb_rise)
   );

   // serial shift register
   logic [FRAME_W-1:0] sr_q, sr_nxt;
   logic               shift_en;

   assign shift_en = pl_s & sck_rise;

   cfg_shift #(.W(FRAME_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(shift_en),
      .din     (sd_s),
      .q       (sr_q),
      .nxt     (sr_nxt)
   );

   // choose the source of the next active values
   upd_src_e src;

   always_comb begin
      if (!pl_s)                               src = SRC_PAR;
      else if (strb_rise || (strb_s && sck_rise)) src = SRC_SER;
      else                                     src = SRC_HOLD;
   end

   cfg_active #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_active (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src),
      .par_m   (par_m_s),
      .par_n   (par_n_s),
      .ser_word(sr_nxt),
      .m_q     (m_val),
      .n_q     (n_val),
      .t_q     (t_val)
   );

   assign ser_out = sr_q[FRAME_W-1];
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
   parameter int M_W = 9,
   parameter int N_W = 2,
   parameter int T_W = 3,
   localparam int FW = T_W + N_W + M_W
) (
   input logic           clk,
   input logic           rst_n,
   input logic           pl_s,
   input logic [M_W-1:0] m_s,
   input logic [N_W-1:0] n_s,
   input logic           sd_s,
   input logic           strb_s,
   input logic           sck_rise,
   input logic           strb_rise,
   input logic [FW-1:0]  sr_q,
   input logic [M_W-1:0] m_out,
   input logic [N_W-1:0] n_out,
   input logic [T_W-1:0] t_out
);
   a_r2_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !pl_s |=> (m_out == $past(m_s) && n_out == $past(n_s) && t_out == '0));

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_s && !strb_rise && !(strb_s && sck_rise)) |=> $stable({t_out, n_out, m_out}));

   a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_s && sck_rise) |=> (sr_q == {$past(sr_q[FW-2:0]), $past(sd_s)}));

   a_r5_strobe_load: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_s && strb_rise && !sck_rise) |=> ({t_out, n_out, m_out} == $past(sr_q)));

   a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_s && strb_s && sck_rise) |=> ({t_out, n_out, m_out} == sr_q));

   a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      !pl_s |=> $stable(sr_q));
endmodule

bind cfg_loader cfg_loader_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pl_s     (pl_s),
   .m_s      (par_m_s),
   .n_s      (par_n_s),
   .sd_s     (sd_s),
   .strb_s   (strb_s),
   .sck_rise (sck_rise),
   .strb_rise(strb_rise),
   .sr_q     (sr_q),
   .m_out    (m_val),
   .n_out    (n_val),
   .t_out    (t_val)
);

// File: tb/test_cfg_loader.sv
`timescale 1ns/1ps
module test_cfg_loader;
   localparam int MW = 9;
   localparam int NW = 2;
   localparam int TW = 3;
   localparam int FW = TW + NW + MW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          par_load_n;
   logic [MW-1:0] par_m;
   logic [NW-1:0] par_n;
   logic          ser_clk, ser_data, ser_strobe;
   logic [MW-1:0] m_val;
   logic [NW-1:0] n_val;
   logic [TW-1:0] t_val;
   logic          ser_out;

   always #2.5 clk = ~clk;

   cfg_loader i_cfg_loader (
      .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
      .ser_clk(ser_clk), .ser_data(ser_data), .ser_strobe(ser_strobe),
      .m_val(m_val), .n_val(n_val), .t_val(t_val), .ser_out(ser_out)
   );

   typedef struct {
      string         tag;
      logic [MW-1:0] m;
      logic [NW-1:0] n;
      logic [TW-1:0] t;
      logic          so;
   } exp_t;

   exp_t          sb[$];
   int            total = 0;
   int            bad = 0;
   logic [FW-1:0] msr = '0;

   // monitor: pops expected items and compares against the ports
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         total++;
         if (m_val !== e.m || n_val !== e.n || t_val !== e.t || ser_out !== e.so) begin
            bad++;
            $display("FAIL %s: got m=%h n=%h t=%h so=%b, expected m=%h n=%h t=%h so=%b",
                     e.tag, m_val, n_val, t_val, ser_out, e.m, e.n, e.t, e.so);
         end
      end
   end

   task automatic settle();
      repeat (5) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_cfg(string tag, logic [MW-1:0] m, logic [NW-1:0] n,
                             logic [TW-1:0] t, logic so);
      exp_t e;
      e.tag = tag; e.m = m; e.n = n; e.t = t; e.so = so;
      sb.push_back(e);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic sclk_pulse(logic d, bit chk_pass, string tag);
      ser_data = d;
      settle();
      ser_clk = 1'b1;
      settle();
      if (par_load_n) msr = {msr[FW-2:0], d};
      if (chk_pass) expect_cfg(tag, msr[MW-1:0], msr[MW+NW-1:MW], msr[FW-1:MW+NW], msr[FW-1]);
      ser_clk = 1'b0;
      settle();
   endtask

   task automatic send_frame(logic [TW-1:0] t, logic [NW-1:0] n, logic [MW-1:0] m);
      logic [FW-1:0] w;
      w = {t, n, m};
      for (int i = FW - 1; i >= 0; i--) sclk_pulse(w[i], 1'b0, "");
   endtask

   task automatic strobe_up();
      ser_strobe = 1'b1;
      settle();
   endtask

   task automatic strobe_down();
      ser_strobe = 1'b0;
      settle();
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      par_load_n = 1'b1; par_m = '0; par_n = '0;
      ser_clk = 1'b0; ser_data = 1'b0; ser_strobe = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      settle();

      // R1: reset state
      expect_cfg("R1 reset state", '0, '0, '0, 1'b0);

      // R2: transparent parallel path, two words, test code forced to zero
      par_m = 9'h1A5; par_n = 2'd2; par_load_n = 1'b0;
      settle();
      expect_cfg("R2 transparent word 1", 9'h1A5, 2'd2, 3'd0, 1'b0);
      par_m = 9'h0FF; par_n = 2'd1;
      settle();
      expect_cfg("R2 transparent word 2", 9'h0FF, 2'd1, 3'd0, 1'b0);

      // R3: latch on rising edge, then change the inputs
      par_load_n = 1'b1;
      settle();
      par_m = 9'h003; par_n = 2'd3;
      settle();
      expect_cfg("R3 parallel latched hold", 9'h0FF, 2'd1, 3'd0, 1'b0);

      // R4 / R7: shift a frame with strobe low; active values unaffected
      send_frame(3'd5, 2'd3, 9'h12C);
      expect_cfg("R4 frame shifted, MSB out; R7 hold", 9'h0FF, 2'd1, 3'd0, msr[FW-1]);
      if (msr !== {3'd5, 2'd3, 9'h12C}) begin
         total++; bad++;
         $display("FAIL R4 bench frame model: got %h expected %h", msr, {3'd5, 2'd3, 9'h12C});
      end

      // R5 / R9: strobe rise commits the frame over the parallel values
      strobe_up();
      expect_cfg("R5 R9 strobe commit", 9'h12C, 2'd3, 3'd5, 1'b1);
      strobe_down();
      expect_cfg("R7 hold after strobe fall", 9'h12C, 2'd3, 3'd5, 1'b1);

      // R7: another frame with the strobe low leaves active values
      send_frame(3'd2, 2'd1, 9'h0B7);
      expect_cfg("R7 second frame no effect", 9'h12C, 2'd3, 3'd5, 1'b0);

      // R6: strobe held high, each serial clock passes through
      strobe_up();
      expect_cfg("R5 commit second frame", 9'h0B7, 2'd1, 3'd2, 1'b0);
      sclk_pulse(1'b1, 1'b1, "R6 pass-through bit a");
      sclk_pulse(1'b0, 1'b1, "R6 pass-through bit b");
      sclk_pulse(1'b1, 1'b1, "R6 pass-through bit c");
      strobe_down();
      expect_cfg("R7 hold after pass-through", msr[MW-1:0], msr[MW+NW-1:MW], msr[FW-1:MW+NW], msr[FW-1]);

      // R9: parallel low overrides serial values
      par_m = 9'h055; par_n = 2'd0; par_load_n = 1'b0;
      settle();
      expect_cfg("R9 parallel overrides serial", 9'h055, 2'd0, 3'd0, msr[FW-1]);

      // R8: serial clocks with parallel low do not shift
      sclk_pulse(1'b1, 1'b0, "");
      sclk_pulse(1'b0, 1'b0, "");
      sclk_pulse(1'b0, 1'b0, "");
      expect_cfg("R8 no shift while parallel low", 9'h055, 2'd0, 3'd0, msr[FW-1]);
      par_load_n = 1'b1;
      settle();
      strobe_up();
      expect_cfg("R8 register unchanged at commit", msr[MW-1:0], msr[MW+NW-1:MW], msr[FW-1:MW+NW], msr[FW-1]);
      strobe_down();

      // R10: all-ones frame
      send_frame(3'h7, 2'h3, 9'h1FF);
      strobe_up();
      expect_cfg("R10 all ones frame", 9'h1FF, 2'h3, 3'h7, 1'b1);
      strobe_down();

      // R10 / R2: largest parallel value
      par_m = 9'h1FF; par_n = 2'h3; par_load_n = 1'b0;
      settle();
      expect_cfg("R10 R2 parallel all ones", 9'h1FF, 2'h3, 3'h0, 1'b1);
      par_load_n = 1'b1;
      settle();

      while (sb.size() > 0) @(negedge clk);
      finish_run();
   end
endmodule